// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block turns an asynchronous, possibly noisy, active-low reset pin into a clean internal reset for a small processor core. The pin first passes through a two-flop synchronizer. A run-length filter then rejects any low excursion of four clocks or fewer. A low level that survives the filter latches the internal reset, which is then held for a minimum of eighteen clocks. If the pin is still low when that minimum ends, the reset lasts until the pin returns high.

While the internal reset is asserted, the block drives the external bus strobes to fixed values. The data strobe is held low, and the address strobe inverts on every clock. When reset ends, the block emits a single-cycle start pulse. During that pulse it presents the fixed program-counter start address 0x000C.

The `rst` input is the block's own synchronous initialisation. It returns the block to the idle state and is not the filtered reset path.

Top module: `rst_filter_seq`

## Requirements
- R1: A low on `ext_rst_n` lasting four clocks or fewer never raises `core_rst`.
- R2: If `ext_rst_n` is driven low just before clock edge 1 and stays low for at least five clocks, `core_rst` is first high after edge 7. That is two synchronizer stages plus qualification on the fifth low sample.
- R3: Once raised, `core_rst` stays high for at least 18 consecutive cycles.
- R4: For a low of N clocks (N ≥ 5), `core_rst` falls at edge max(25, N+3). The reset therefore lasts as long as the pin stays low, plus the synchronizer delay.
- R5: `ds_n` is 0 in exactly the cycles where `core_rst` is 1, and 1 otherwise.
- R6: `as_n` is 0 in the first reset cycle and inverts on every clock while `core_rst` is 1. It is 1 whenever `core_rst` is 0.
- R7: `start_pulse` is high for exactly one cycle, the cycle immediately after `core_rst` falls.
- R8: `start_addr` equals 16'h000C while `start_pulse` is 1, and 16'h0000 otherwise.
- R9: The low-run count restarts whenever the synchronized pin is seen high. Two four-clock lows separated by a single high clock cause no reset.
- R10: While `rst` is high, the outputs are `core_rst`=0, `ds_n`=1, `as_n`=1, `start_pulse`=0 and `start_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high initialisation of the block |
| ext_rst_n | input | 1 | Asynchronous active-low reset pin |
| core_rst | output | 1 | Filtered, stretched internal reset, active high |
| ds_n | output | 1 | Data strobe, held low during reset |
| as_n | output | 1 | Address strobe, toggling during reset |
| start_pulse | output | 1 | One-cycle pulse when reset ends |
| start_addr | output | 16 | Program-counter start address, valid with `start_pulse` |

## Verification
A filter count that is off by one shows up as `core_rst` rising one edge early or late, or as a four-clock glitch that is wrongly accepted. Either appears within seven edges of the pin falling. A hold counter or release condition that is wrong moves the falling edge of `core_rst` away from max(25, N+3), and the start pulse moves with it. A wrong strobe phase register is visible on `as_n` in the very first reset cycle. Random low widths from 1 to 40 clocks are mixed with directed widths at 4, 5, 22, 23 and a split low, so that both the fixed-minimum release and the pin-limited release are covered.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned ADDR_W      = 16;
    localparam logic [ADDR_W-1:0] START_VEC = 16'h000C;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_HOLD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic ds_n;
        logic as_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ds_n: 1'b1, as_n: 1'b1};

    // Strobe pattern for the next cycle, given whether reset stays on.
    function automatic strobe_t next_strobe(input logic in_rst,
                                            input logic entering,
                                            input strobe_t cur);
        strobe_t s;
        if (!in_rst) begin
            s = STROBE_IDLE;
        end else if (entering) begin
            s.ds_n = 1'b0;
            s.as_n = 1'b0;
        end else begin
            s.ds_n = 1'b0;
            s.as_n = ~cur.as_n;
        end
        return s;
    endfunction

endpackage

// File: rtl/rfs_sync.sv
module rfs_sync #(
    parameter int unsigned STAGES = rfs_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rfs_filter.sv
module rfs_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic low_seen,
    input  logic armed,
    output logic qualify
);
    localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN);

    logic [CNT_W-1:0] run_q;

    // Qualify on the sample after FILT_LEN consecutive low samples.
    assign qualify = armed && low_seen && (run_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!armed || !low_seen) begin
            run_q <= '0;
        end else if (run_q != CNT_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfs_hold.sv
module rfs_hold
    import rfs_pkg::*;
#(
    parameter int unsigned HOLD_LEN = 18
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    qualify,
    input  logic    low_seen,
    output logic    in_rst,
    output strobe_t strobes,
    output logic    start_q
);
    localparam int unsigned HOLD_W = $clog2(HOLD_LEN + 1);
    localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_LEN);

    seq_state_e       state_q, state_d;
    logic [HOLD_W-1:0] hold_q, hold_d;
    strobe_t          strobe_q;
    logic             start_d;

    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        start_d = 1'b0;
        unique case (state_q)
            SQ_IDLE: begin
                if (qualify) begin
                    state_d = SQ_HOLD;
                    hold_d  = HOLD_W'(1);
                end
            end
            SQ_HOLD: begin
                if (hold_q == HOLD_MAX && !low_seen) begin
                    state_d = SQ_IDLE;
                    hold_d  = '0;
                    start_d = 1'b1;
                end else if (hold_q != HOLD_MAX) begin
                    hold_d = hold_q + 1'b1;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            hold_q   <= '0;
            strobe_q <= STROBE_IDLE;
            start_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            hold_q   <= hold_d;
            strobe_q <= next_strobe(state_d == SQ_HOLD,
                                    state_q == SQ_IDLE, strobe_q);
            start_q  <= start_d;
        end
    end

    assign in_rst  = (state_q == SQ_HOLD);
    assign strobes = strobe_q;
endmodule

// File: rtl/rst_filter_seq.sv
module rst_filter_seq
    import rfs_pkg::*;
#(
    parameter int unsigned FILT_LEN = 4,
    parameter int unsigned HOLD_LEN = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    output logic              core_rst,
    output logic              ds_n,
    output logic              as_n,
    output logic              start_pulse,
    output logic [ADDR_W-1:0] start_addr
);
    logic    pin_sync;
    logic    low_seen;
    logic    qualify;
    logic    in_rst;
    logic    start_q;
    strobe_t strobes;

    rfs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_rst_n),
        .sync_out (pin_sync)
    );

    assign low_seen = ~pin_sync;

    rfs_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .low_seen (low_seen),
        .armed    (~in_rst),
        .qualify  (qualify)
    );

    rfs_hold #(.HOLD_LEN(HOLD_LEN)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .qualify  (qualify),
        .low_seen (low_seen),
        .in_rst   (in_rst),
        .strobes  (strobes),
        .start_q  (start_q)
    );

    assign core_rst    = in_rst;
    assign ds_n        = strobes.ds_n;
    assign as_n        = strobes.as_n;
    assign start_pulse = start_q;
    assign start_addr  = start_q ? START_VEC : '0;
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
    parameter int unsigned HOLD_LEN = 18
) (
    input logic        clk,
    input logic        rst,
    input logic        core_rst,
    input logic        ds_n,
    input logic        as_n,
    input logic        start_pulse,
    input logic [15:0] start_addr
);
    int unsigned run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 0;
        end else if (core_rst) begin
            if (run_q < HOLD_LEN + 1) run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> (run_q >= HOLD_LEN)); // R3

    AST_DS_TRACKS_RST: assert property (@(posedge clk) disable iff (rst)
        (ds_n == !core_rst)); // R5

    AST_AS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (core_rst && $past(core_rst)) |-> (as_n != $past(as_n))); // R6

    AST_AS_FIRST_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst) |-> !as_n); // R6

    AST_AS_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !core_rst |-> as_n); // R6

    AST_START_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst) |-> start_pulse); // R7

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse); // R7

    AST_START_ADDR: assert property (@(posedge clk) disable iff (rst)
        start_addr == (start_pulse ? 16'h000C : 16'h0000)); // R8
endmodule

bind rst_filter_seq rfs_checker #(.HOLD_LEN(HOLD_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .core_rst    (core_rst),
    .ds_n        (ds_n),
    .as_n        (as_n),
    .start_pulse (start_pulse),
    .start_addr  (start_addr)
);

// File: tb/sim_rst_filter_seq.sv
module sim_rst_filter_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 18;
    localparam int SEED       = 1234;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        core_rst, ds_n, as_n, start_pulse;
    logic [15:0] start_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_filter_seq u0 (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n),
        .core_rst(core_rst), .ds_n(ds_n), .as_n(as_n),
        .start_pulse(start_pulse), .start_addr(start_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rel_edge(input int n);
        return (n + 3 > 7 + HOLD) ? n + 3 : 7 + HOLD;
    endfunction

    function automatic bit exp_rst(input int n, input int e);
        return (n >= 5) && (e >= 7) && (e < rel_edge(n));
    endfunction

    function automatic string rst_tag(input int n, input int e);
        if (n < 5)         return "R1";
        if (e <= 7)        return "R2";
        if (e < 7 + HOLD)  return "R3";
        return "R4";
    endfunction

    // Low for n clocks, driven just before edge 1; check every cycle.
    task automatic run_low(input int n);
        int last;
        bit r;
        last = ((n >= 5) ? rel_edge(n) : n + 3) + 3;
        @(negedge clk);
        ext_rst_n = 1'b0;
        for (int e = 1; e <= last; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == n) ext_rst_n = 1'b1;
            r = exp_rst(n, e);
            chk(rst_tag(n, e), int'(core_rst), int'(r));
            chk("R5", int'(ds_n), int'(!r));
            chk("R6", int'(as_n), r ? ((e - 7) % 2) : 1);
            chk("R7", int'(start_pulse), int'(n >= 5 && e == rel_edge(n)));
            chk("R8", int'(start_addr),
                (n >= 5 && e == rel_edge(n)) ? 32'h000C : 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", int'(core_rst), 0);
        chk("R10", int'(ds_n), 1);
        chk("R10", int'(as_n), 1);
        chk("R10", int'(start_pulse), 0);
        chk("R10", int'(start_addr), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // Directed widths around the filter and hold boundaries (R1..R4)
        run_low(4);
        run_low(1);
        run_low(5);
        run_low(22);
        run_low(23);
        run_low(30);

        // R9: split low, 4 low + 1 high + 4 low, must not reset
        @(negedge clk);
        ext_rst_n = 1'b0;
        for (int e = 1; e <= 16; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (e == 4) ext_rst_n = 1'b1;
            if (e == 5) ext_rst_n = 1'b0;
            if (e == 9) ext_rst_n = 1'b1;
            chk("R9", int'(core_rst), 0);
        end
        repeat (3) @(negedge clk);

        // Random widths with fixed seed
        void'($urandom(SEED));
        for (int k = 0; k < 40; k++) begin
            run_low(int'($urandom_range(40, 1)));
        end

        // R10: reset of the block mid-sequence returns to idle
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R10", int'(core_rst), 0);
        chk("R10", int'(as_n), 1);
        ext_rst_n = 1'b1;
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule